// File: doc/BRIEF.md
# Nested Interrupt Level Arbiter

This block sits between a set of peripheral interrupt sources and the processor. Every source carries a 3-bit priority level taken from its own control field. Requests are latched as pending. The block compares each pending level against a current-level mask and a global enable, and picks at most one winner per cycle. The winner is acknowledged with a one-cycle pulse that carries its source index.

For a normal handler, the mask in force is pushed onto a level stack on acknowledge, and the accepted level becomes the new mask. When the handler signals return, the stack is popped and the interrupted handler's level is restored. A more urgent request can therefore suspend a running handler, and the suspended handler resumes when the urgent one ends.

Sources flagged for hardware transfer service behave differently. Their acknowledge raises a busy flag and leaves the mask and the stack alone. While the flag is set, nothing else is acknowledged. The transfer engine clears the flag with a done pulse.

Top module: `irq_nest_arb`

## Requirements
- R1: After reset, ack_o and busy_o are 0 and mask_o is 7.
- R2: A source whose level is 7 is never acknowledged, under any mask or enable setting.
- R3: A pending source is acknowledged only when gie_i is 1 and its level is numerically less than mask_o. Smaller numbers are more urgent. For a non-transfer source, mask_o equals the accepted level in the cycle ack_o is high, and the previous mask is pushed onto the stack.
- R4: A request whose level is equal to or greater than mask_o does not preempt. It stays pending and is acknowledged once a return lowers the urgency threshold enough.
- R5: A ret_i pulse pops the stack into mask_o in the next cycle. A ret_i with an empty stack leaves mask_o unchanged.
- R6: With gie_i at 0, or with mask_o at 0, nothing is acknowledged. Pending requests are kept and are served once acceptance is allowed again.
- R7: Among eligible requests, the smallest level wins. On equal levels, the lowest source index wins.
- R8: ack_o is a one-cycle pulse, and ack_id_o carries the winning index. The winner's pending bit is cleared, so one request yields exactly one acknowledge.
- R9: Acknowledging a source with hw_svc_i set drives ack_hw_o to 1, sets busy_o and leaves mask_o unchanged. While busy_o is set, no other request is acknowledged, whether normal or transfer. xfer_done_i clears busy_o, and arbitration resumes in the cycle after busy_o falls.
- R10: mask_wr_i loads mask_wdata_i into mask_o in the next cycle. A cycle with mask_wr_i or ret_i high produces no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_SRC | Request strobes; each high cycle sets that source's pending bit |
| lvl_cfg_i | input | N_SRC*3 | Level per source; source i uses bits [3i+2:3i] |
| hw_svc_i | input | N_SRC | Source is served by the transfer engine rather than a handler |
| gie_i | input | 1 | Global interrupt enable |
| mask_wr_i | input | 1 | Load the mask from mask_wdata_i |
| mask_wdata_i | input | 3 | New mask value |
| ret_i | input | 1 | Handler return strobe; pops the level stack |
| xfer_done_i | input | 1 | Transfer engine finished; clears busy |
| ack_o | output | 1 | One-cycle acknowledge |
| ack_id_o | output | $clog2(N_SRC) | Index of the acknowledged source |
| ack_hw_o | output | 1 | Acknowledge is for a transfer-service source |
| mask_o | output | 3 | Current level mask |
| busy_o | output | 1 | Hardware transfer in progress |

## Verification
A corrupted stack entry shows up at the first return as a wrong mask_o value one cycle after ret_i. It also shows up as the wrong pending request being released, or as a request that is never released. A pending bit that fails to clear shows up as a duplicate acknowledge within two cycles. A lost pending bit shows up as a missing acknowledge once the mask allows it. A stuck busy flag shows up as a request that stays unacknowledged after xfer_done_i. The scoreboard catches each of these as an unexpected, missing or reordered acknowledge, or as a wrong mask_o in a fixed cycle after the stimulus.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  localparam int unsigned LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_NEVER = '1;
  localparam lvl_t MASK_RST  = '1;
endpackage

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int unsigned N_SRC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] set_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] pend_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       pend_o[i] <= 1'b0;
      else if (set_i[i]) pend_o[i] <= 1'b1;
      else if (clr_i[i]) pend_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_nest_pkg::*;
#(
  parameter int unsigned N_SRC = 8,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]       pend_i,
  input  logic [N_SRC*LVL_W-1:0] lvl_cfg_i,
  input  lvl_t                   mask_i,
  input  logic                   en_i,
  output logic                   vld_o,
  output logic [IDX_W-1:0]       idx_o,
  output lvl_t                   lvl_o
);
  logic [N_SRC-1:0] elig;
  lvl_t             lvl_a [N_SRC];

  for (genvar i = 0; i < N_SRC; i++) begin : g_elig
    assign lvl_a[i] = lvl_cfg_i[i*LVL_W +: LVL_W];
    assign elig[i]  = en_i && pend_i[i] && (lvl_a[i] != LVL_NEVER) && (lvl_a[i] < mask_i);
  end

  // strict compare keeps the lowest index on equal levels
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    lvl_o = LVL_NEVER;
    for (int i = 0; i < N_SRC; i++) begin
      if (elig[i] && (!vld_o || lvl_a[i] < lvl_o)) begin
        vld_o = 1'b1;
        idx_o = IDX_W'(i);
        lvl_o = lvl_a[i];
      end
    end
  end
endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack
  import irq_nest_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_i,
  input  logic pop_i,
  input  lvl_t din_i,
  output lvl_t top_o,
  output logic empty_o,
  output logic full_o
);
  lvl_t             mem [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  assign wr_ptr  = cnt_q[PTR_W-1:0];
  assign rd_ptr  = wr_ptr - 1'b1;
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign top_o   = mem[rd_ptr];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= MASK_RST;
    end else if (push_i && !full_o) begin
      mem[wr_ptr] <= din_i;
      cnt_q       <= cnt_q + 1'b1;
    end else if (pop_i && !empty_o) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/irq_nest_arb.sv
module irq_nest_arb
  import irq_nest_pkg::*;
#(
  parameter int unsigned N_SRC     = 8,
  parameter int unsigned STK_DEPTH = 8,
  localparam int unsigned IDX_W    = $clog2(N_SRC)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_SRC-1:0]       req_i,
  input  logic [N_SRC*LVL_W-1:0] lvl_cfg_i,
  input  logic [N_SRC-1:0]       hw_svc_i,
  input  logic                   gie_i,
  input  logic                   mask_wr_i,
  input  logic [LVL_W-1:0]       mask_wdata_i,
  input  logic                   ret_i,
  input  logic                   xfer_done_i,
  output logic                   ack_o,
  output logic [IDX_W-1:0]       ack_id_o,
  output logic                   ack_hw_o,
  output logic [LVL_W-1:0]       mask_o,
  output logic                   busy_o
);
  logic [N_SRC-1:0] pend, clr;
  logic             arb_en, win_vld, win_hw, take, push, pop;
  logic [IDX_W-1:0] win_idx;
  lvl_t             win_lvl, stk_top, mask_q;
  logic             stk_empty, stk_full, busy_q;

  // no grant during busy, return, mask write, or when a push could not be stored
  assign arb_en = gie_i && !busy_q && !ret_i && !mask_wr_i && !stk_full;
  assign win_hw = hw_svc_i[win_idx];
  assign take   = win_vld;
  assign push   = take && !win_hw;
  assign pop    = ret_i && !stk_empty;

  for (genvar i = 0; i < N_SRC; i++) begin : g_clr
    assign clr[i] = take && (win_idx == IDX_W'(i));
  end

  irq_pend #(.N_SRC(N_SRC)) i_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (req_i),
    .clr_i  (clr),
    .pend_o (pend)
  );

  irq_pick #(.N_SRC(N_SRC)) i_pick (
    .pend_i    (pend),
    .lvl_cfg_i (lvl_cfg_i),
    .mask_i    (mask_q),
    .en_i      (arb_en),
    .vld_o     (win_vld),
    .idx_o     (win_idx),
    .lvl_o     (win_lvl)
  );

  irq_lvl_stack #(.DEPTH(STK_DEPTH)) i_stack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .pop_i   (pop),
    .din_i   (mask_q),
    .top_o   (stk_top),
    .empty_o (stk_empty),
    .full_o  (stk_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= MASK_RST;
    else if (mask_wr_i) mask_q <= mask_wdata_i;
    else if (pop)       mask_q <= stk_top;
    else if (push)      mask_q <= win_lvl;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              busy_q <= 1'b0;
    else if (xfer_done_i)     busy_q <= 1'b0;
    else if (take && win_hw)  busy_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o    <= 1'b0;
      ack_id_o <= '0;
      ack_hw_o <= 1'b0;
    end else begin
      ack_o    <= take;
      ack_id_o <= take ? win_idx : ack_id_o;
      ack_hw_o <= take && win_hw;
    end
  end

  assign mask_o = mask_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/irq_nest_chk.sv
module irq_nest_chk
  import irq_nest_pkg::*;
#(
  parameter int unsigned N_SRC     = 8,
  parameter int unsigned STK_DEPTH = 8,
  localparam int unsigned IDX_W    = $clog2(N_SRC)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [N_SRC*LVL_W-1:0] lvl_cfg_i,
  input logic                   gie_i,
  input logic                   mask_wr_i,
  input logic                   ret_i,
  input logic                   ack_o,
  input logic [IDX_W-1:0]       ack_id_o,
  input logic                   ack_hw_o,
  input logic [LVL_W-1:0]       mask_o,
  input logic                   busy_o
);
  logic [N_SRC*LVL_W-1:0] cfg_q;
  lvl_t                   ack_lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= lvl_cfg_i;
  end
  assign ack_lvl = cfg_q[ack_id_o*LVL_W +: LVL_W];

  a_r2_never_lvl7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (ack_lvl != LVL_NEVER));
  a_r3_mask_takes_lvl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && !ack_hw_o) |-> (mask_o == ack_lvl));
  a_r6_needs_gie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(gie_i));
  a_r9_hold_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> !ack_o);
  a_r9_hw_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_hw_o |-> busy_o);
  a_r10_quiet_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i || mask_wr_i) |=> !ack_o);
endmodule

bind irq_nest_arb irq_nest_chk #(.N_SRC(N_SRC), .STK_DEPTH(STK_DEPTH)) i_chk (.*);

// File: tb/test_irq_nest_arb.sv
`timescale 1ns/1ps
module test_irq_nest_arb;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req_i = '0;
  logic [N*3-1:0] lvl_cfg = '0;
  logic [N-1:0] hw_svc = '0;
  logic         gie = 1'b1;
  logic         mask_wr = 1'b0;
  logic [2:0]   mask_wdata = '0;
  logic         ret = 1'b0;
  logic         xfer_done = 1'b0;
  logic         ack_o, ack_hw_o, busy_o;
  logic [2:0]   ack_id_o, mask_o;

  int compared = 0, mismatched = 0, ack_seen = 0;
  int exp_q[$];
  bit finished = 0;

  always #2.5 clk = ~clk;

  irq_nest_arb #(.N_SRC(N), .STK_DEPTH(8)) i_irq_nest_arb (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req_i), .lvl_cfg_i(lvl_cfg),
    .hw_svc_i(hw_svc), .gie_i(gie), .mask_wr_i(mask_wr), .mask_wdata_i(mask_wdata),
    .ret_i(ret), .xfer_done_i(xfer_done), .ack_o(ack_o), .ack_id_o(ack_id_o),
    .ack_hw_o(ack_hw_o), .mask_o(mask_o), .busy_o(busy_o)
  );

  // monitor: every acknowledge is compared against the queue head
  always @(negedge clk) begin
    if (rst_n && ack_o) begin
      int got;
      ack_seen++;
      compared++;
      got = ack_id_o * 2 + ack_hw_o;
      if (exp_q.size() == 0) begin
        mismatched++;
        $display("FAIL R8: unexpected ack id=%0d hw=%0d, expected none", ack_id_o, ack_hw_o);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (got != e) begin
          mismatched++;
          $display("FAIL R7/R8: ack id=%0d hw=%0d, expected id=%0d hw=%0d",
                   ack_id_o, ack_hw_o, e / 2, e % 2);
        end
      end
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_ack(input int id, input bit hw);
    exp_q.push_back(id * 2 + hw);
  endtask

  task automatic set_lvl(input int src, input int lvl);
    lvl_cfg[src*3 +: 3] = 3'(lvl);
  endtask

  task automatic pulse_req(input logic [N-1:0] v);
    req_i = v; tick(); req_i = '0;
  endtask

  task automatic do_ret();
    ret = 1'b1; tick(); ret = 1'b0;
  endtask

  task automatic expect_none(input int n, input string req);
    int s;
    s = ack_seen;
    tick(n);
    chk(ack_seen == s, req, ack_seen - s, 0);
  endtask

  task automatic chk_mask(input int exp, input string req);
    chk(mask_o == 3'(exp), req, mask_o, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) set_lvl(i, 6);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    // R1
    chk(ack_o == 1'b0, "R1 ack", ack_o, 0);
    chk(busy_o == 1'b0, "R1 busy", busy_o, 0);
    chk_mask(7, "R1 mask");

    // R2: level 7 never taken
    set_lvl(0, 7);
    pulse_req(8'b0000_0001);
    expect_none(5, "R2 lvl7 acked");
    chk_mask(7, "R2 mask");

    // R3/R8: single request
    set_lvl(1, 4);
    expect_ack(1, 0);
    pulse_req(8'b0000_0010);
    tick();
    chk(ack_o == 1'b1, "R8 ack pulse high", ack_o, 1);
    chk_mask(4, "R3 mask after ack");
    tick();
    chk(ack_o == 1'b0, "R8 ack pulse low", ack_o, 0);
    expect_none(3, "R8 duplicate ack");

    // R4: equal level waits; R3 higher preempts; R5 restore
    set_lvl(2, 4);
    pulse_req(8'b0000_0100);
    expect_none(4, "R4 equal level preempted");
    set_lvl(3, 2);
    expect_ack(3, 0);
    pulse_req(8'b0000_1000);
    tick();
    chk_mask(2, "R3 preempt mask");
    do_ret();
    chk_mask(4, "R5 restored level");
    expect_none(3, "R4 equal after restore");
    expect_ack(2, 0);
    do_ret();
    chk_mask(7, "R5 restored outer");
    tick();
    chk_mask(4, "R4 held request served");
    do_ret();
    chk_mask(7, "R5 pop");
    do_ret();
    chk_mask(7, "R5 empty stack ret");
    expect_none(2, "R5 empty ret ack");

    // R6: enable off
    gie = 1'b0;
    set_lvl(4, 1);
    pulse_req(8'b0001_0000);
    expect_none(4, "R6 gie off");
    chk_mask(7, "R6 mask kept");
    expect_ack(4, 0);
    gie = 1'b1;
    tick();
    chk_mask(1, "R6 served after enable");
    do_ret();

    // R6/R10: mask zero blocks, mask write reopens
    mask_wdata = 3'd0; mask_wr = 1'b1; tick(); mask_wr = 1'b0;
    chk_mask(0, "R10 mask write");
    set_lvl(5, 0);
    pulse_req(8'b0010_0000);
    expect_none(4, "R6 mask zero");
    expect_ack(5, 0);
    begin
      int s;
      s = ack_seen;
      mask_wdata = 3'd7; mask_wr = 1'b1; tick(); mask_wr = 1'b0;
      chk_mask(7, "R10 mask reopened");
      chk(ack_seen == s, "R10 ack during write", ack_seen - s, 0);
    end
    tick();
    chk_mask(0, "R6 served after unmask");
    do_ret();
    chk_mask(7, "R5 pop after mask test");

    // R7: level then index ordering
    set_lvl(1, 3); set_lvl(6, 3); set_lvl(2, 5);
    expect_ack(1, 0);
    pulse_req(8'b0100_0110);
    tick();
    chk_mask(3, "R7 first winner level");
    expect_none(2, "R7 equal level while active");
    expect_ack(6, 0);
    do_ret();
    tick();
    chk_mask(3, "R7 second winner level");
    expect_ack(2, 0);
    do_ret();
    tick();
    chk_mask(5, "R7 third winner level");
    do_ret();
    chk_mask(7, "R5 final pop R7");

    // R9: transfer service
    set_lvl(3, 2); hw_svc[3] = 1'b1;
    set_lvl(4, 0); set_lvl(5, 1); hw_svc[5] = 1'b1;
    expect_ack(3, 1);
    pulse_req(8'b0000_1000);
    tick();
    chk(busy_o == 1'b1, "R9 busy set", busy_o, 1);
    chk_mask(7, "R9 mask unchanged");
    pulse_req(8'b0011_0000);
    expect_none(5, "R9 held while busy");
    chk(busy_o == 1'b1, "R9 still busy", busy_o, 1);
    expect_ack(4, 0);
    expect_ack(5, 1);
    begin
      int s;
      s = ack_seen;
      xfer_done = 1'b1; tick(); xfer_done = 1'b0;
      chk(busy_o == 1'b0, "R9 busy cleared", busy_o, 0);
      chk(ack_seen == s, "R9 no ack in done cycle", ack_seen - s, 0);
    end
    tick();
    chk_mask(0, "R9 resumed winner");
    do_ret();
    tick();
    chk(busy_o == 1'b1, "R9 second transfer busy", busy_o, 1);
    chk_mask(7, "R9 mask unchanged 2");
    xfer_done = 1'b1; tick(); xfer_done = 1'b0;
    chk(busy_o == 1'b0, "R9 busy cleared 2", busy_o, 0);
    expect_none(3, "R9 idle after transfers");

    chk(exp_q.size() == 0, "R8 missing acks", exp_q.size(), 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule